// File: doc/BRIEF.md
# Automatic Gain Controller with PWM Drive

This block measures the strength of a stream of complex baseband samples and drives an external variable-gain stage through a single pulse-width-modulated pin. Each accepted I/Q pair contributes its instantaneous power. The powers are summed over a window of a power-of-two number of samples. The mean of that sum is then published as an 8-bit level that a host can read.

One 8-bit configuration byte serves two roles, chosen by a mode input. In direct mode the byte is the gain itself, and the pin carries it as a duty cycle. The host is then expected to close the loop in software by watching the level readback. In regulate mode the byte is a target level. At the end of every measurement window the block moves its internal gain one step toward the value that makes the readback match the target.

A polarity input decides whether more gain means more high time or more low time on the pin. This suits gain stages with either control sense. The analog smoothing after the pin is outside the block.

Top module: `agc_ctrl`

## Requirements
- R1: For every sample with `smp_vld` high, the power is I*I + Q*Q. Here I and Q are two's complement `SAMPLE_W`-bit values, and the power is held as a 16-bit value. The readback `lvl_rd` equals bits [15:8] of floor(sum of powers / N) over one window of N accepted samples. With the default 8-bit samples, I = Q = -128 gives 0x80.
- R2: The window length N is 2^(TIMER_BASE + `cfg_interval`). With the default TIMER_BASE of 16, code 0 is 65536 samples (about 1.09 ms at 60 MHz) and each code step doubles it, up to about 140 ms at code 7. `lvl_rd` changes only after the N-th accepted sample of a window, and it does so in both modes.
- R3: Cycles with `smp_vld` low add nothing to the window, whatever the sample inputs carry. `lvl_rd` holds its value between window ends.
- R4: With `cfg_direct` = 1, the PWM duty equals `cfg_byte`.
- R5: With `cfg_direct` = 0, `cfg_byte` is the target level and the duty is the internal gain. At each window end the gain rises by 1 if the new readback is below the target, falls by 1 if it is above, and holds if it is equal. At all other times the gain holds.
- R6: In regulate mode the gain saturates at 0x00 and at 0xFF and never wraps.
- R7: While `cfg_direct` = 1, the internal gain follows `cfg_byte` one cycle later. Regulation therefore resumes from the last direct gain.
- R8: The PWM period is 256 clocks, and the duty is taken once per period. With `cfg_pol_pos` = 1 the pin is high for duty clocks of each period. With `cfg_pol_pos` = 0 the pin is low for duty clocks, so it is high for 256 - duty clocks.
- R9: After reset, `lvl_rd` is 0, the internal gain is 0x00, `pwm_o` is low and the window count starts from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_vld | input | 1 | Sample strobe; the I/Q pair is taken when high |
| smp_i | input | SAMPLE_W | In-phase sample, two's complement |
| smp_q | input | SAMPLE_W | Quadrature sample, two's complement |
| cfg_byte | input | 8 | Direct gain (direct mode) or target level (regulate mode) |
| cfg_direct | input | 1 | 1: direct gain, 0: regulate toward target |
| cfg_pol_pos | input | 1 | 1: positive control sense, 0: inverted pin |
| cfg_interval | input | 3 | Window length code |
| lvl_rd | output | 8 | Mean power readback of the last window |
| pwm_o | output | 1 | PWM gain-control pin |

## Verification
The gain assertions assume that `cfg_direct` and `cfg_byte` are synchronous to the clock. They also assume that the window-end pulse is the only event that may move the gain in regulate mode. The level checks assume that `cfg_interval` changes only at a window boundary, because a change in mid-window would mix two window lengths. The stimulus therefore drives every input at the falling edge and always completes whole windows before it picks a new code. It changes the mode and the byte only between windows.

// File: rtl/agc_pkg.sv
package agc_pkg;
  localparam int unsigned PWR_W  = 16;
  localparam int unsigned LVL_W  = 8;
  localparam int unsigned CODE_W = 3;

  typedef logic [LVL_W-1:0] lvl_t;

  typedef enum logic {
    MODE_REGULATE = 1'b0,
    MODE_DIRECT   = 1'b1
  } agc_mode_e;

  // One regulation step toward the target, saturating at both ends.
  function automatic lvl_t gain_step(lvl_t cur, lvl_t meas, lvl_t tgt);
    lvl_t res;
    res = cur;
    if ((meas < tgt) && (cur != {LVL_W{1'b1}})) begin
      res = cur + lvl_t'(1);
    end else if ((meas > tgt) && (cur != '0)) begin
      res = cur - lvl_t'(1);
    end
    return res;
  endfunction
endpackage

// File: rtl/agc_rst_sync.sv
module agc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/agc_power.sv
module agc_power
  import agc_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       smp_vld,
  input  logic signed [SAMPLE_W-1:0] smp_i,
  input  logic signed [SAMPLE_W-1:0] smp_q,
  output logic                       pwr_vld,
  output logic [PWR_W-1:0]           pwr
);
  // A sum of two squares of SAMPLE_W-bit values fits in 2*SAMPLE_W bits.
  localparam int unsigned SQ_W = 2 * SAMPLE_W;

  logic signed [SQ_W-1:0] i_ext, q_ext;
  logic [SQ_W-1:0]        i_sq, q_sq, sq_sum;
  logic [PWR_W-1:0]       pwr_nx;
  logic                   vld_nx;
  logic                   pwr_q;
  logic [PWR_W-1:0]       pwr_val_q;

  assign i_ext  = SQ_W'(smp_i);
  assign q_ext  = SQ_W'(smp_q);
  assign i_sq   = i_ext * i_ext;
  assign q_sq   = q_ext * q_ext;
  assign sq_sum = i_sq + q_sq;

  // Align the square sum to the fixed 16-bit power word.
  generate
    if (SQ_W >= PWR_W) begin : g_trim
      assign pwr_nx = sq_sum[SQ_W-1 -: PWR_W];
    end else begin : g_pad
      assign pwr_nx = {sq_sum, {(PWR_W-SQ_W){1'b0}}};
    end
  endgenerate

  always_comb begin
    vld_nx = smp_vld;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_q     <= 1'b0;
      pwr_val_q <= '0;
    end else begin
      pwr_q <= vld_nx;
      if (smp_vld) begin
        pwr_val_q <= pwr_nx;
      end
    end
  end

  assign pwr_vld = pwr_q;
  assign pwr     = pwr_val_q;
endmodule

// File: rtl/agc_integrator.sv
module agc_integrator
  import agc_pkg::*;
#(
  parameter int unsigned TIMER_BASE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_vld,
  input  logic [PWR_W-1:0]  pwr,
  input  logic [CODE_W-1:0] code,
  output lvl_t              level,
  output logic              lvl_upd
);
  localparam int unsigned MAX_SHIFT = TIMER_BASE + (1 << CODE_W) - 1;
  localparam int unsigned CNT_W     = MAX_SHIFT;
  localparam int unsigned CNTX_W    = CNT_W + 1;
  localparam int unsigned ACC_W     = PWR_W + MAX_SHIFT;
  localparam int unsigned SH_W      = $clog2(MAX_SHIFT + 1);
  localparam int unsigned DROP      = PWR_W - LVL_W;

  logic [CNT_W-1:0]  cnt_q, cnt_nx;
  logic [ACC_W-1:0]  acc_q, acc_nx, acc_sum;
  lvl_t              lvl_q, lvl_nx;
  logic              upd_q, upd_nx;
  logic [SH_W-1:0]   shift;
  logic [CNTX_W-1:0] span;
  logic              at_end;
  logic              win_en;

  assign shift   = SH_W'(TIMER_BASE) + SH_W'(code);
  assign span    = CNTX_W'(1) << shift;
  assign at_end  = ({1'b0, cnt_q} >= (span - CNTX_W'(1)));
  assign acc_sum = acc_q + ACC_W'(pwr);
  assign win_en  = pwr_vld;

  always_comb begin
    cnt_nx = cnt_q;
    acc_nx = acc_q;
    lvl_nx = lvl_q;
    upd_nx = 1'b0;
    if (pwr_vld) begin
      if (at_end) begin
        cnt_nx = '0;
        acc_nx = '0;
        lvl_nx = LVL_W'(acc_sum >> (32'(shift) + DROP));
        upd_nx = 1'b1;
      end else begin
        cnt_nx = cnt_q + CNT_W'(1);
        acc_nx = acc_sum;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      acc_q <= '0;
      lvl_q <= '0;
      upd_q <= 1'b0;
    end else begin
      upd_q <= upd_nx;
      if (win_en) begin
        cnt_q <= cnt_nx;
        acc_q <= acc_nx;
        lvl_q <= lvl_nx;
      end
    end
  end

  assign level   = lvl_q;
  assign lvl_upd = upd_q;
endmodule

// File: rtl/agc_gain_loop.sv
module agc_gain_loop
  import agc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_direct,
  input  lvl_t cfg_byte,
  input  lvl_t level,
  input  logic lvl_upd,
  output lvl_t gain
);
  agc_mode_e mode;
  lvl_t      gain_q, gain_nx;
  logic      gain_en;

  assign mode = agc_mode_e'(cfg_direct);

  always_comb begin
    gain_nx = gain_q;
    gain_en = 1'b0;
    case (mode)
      MODE_DIRECT: begin
        gain_nx = cfg_byte;
        gain_en = 1'b1;
      end
      default: begin
        gain_nx = gain_step(gain_q, level, cfg_byte);
        gain_en = lvl_upd;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gain_q <= '0;
    end else if (gain_en) begin
      gain_q <= gain_nx;
    end
  end

  assign gain = gain_q;
endmodule

// File: rtl/agc_pwm.sv
module agc_pwm
  import agc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  lvl_t duty,
  input  logic pol_pos,
  output logic pwm_o
);
  lvl_t cnt_q, cnt_nx;
  lvl_t duty_q;
  logic duty_en;
  logic pin_q, pin_nx;

  assign duty_en = (cnt_q == {LVL_W{1'b1}});

  always_comb begin
    cnt_nx = cnt_q + lvl_t'(1);
    // The comparator result is inverted afterwards for the negative sense.
    pin_nx = (cnt_q < duty_q) ^ ~pol_pos;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      duty_q <= '0;
      pin_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_nx;
      pin_q <= pin_nx;
      if (duty_en) begin
        duty_q <= duty;
      end
    end
  end

  assign pwm_o = pin_q;
endmodule

// File: rtl/agc_ctrl.sv
module agc_ctrl
  import agc_pkg::*;
#(
  parameter int unsigned SAMPLE_W   = 8,
  parameter int unsigned TIMER_BASE = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_vld,
  input  logic [SAMPLE_W-1:0] smp_i,
  input  logic [SAMPLE_W-1:0] smp_q,
  input  logic [7:0]          cfg_byte,
  input  logic                cfg_direct,
  input  logic                cfg_pol_pos,
  input  logic [2:0]          cfg_interval,
  output logic [7:0]          lvl_rd,
  output logic                pwm_o
);
  logic             rst_sync_n;
  logic             pwr_vld;
  logic [PWR_W-1:0] pwr;
  lvl_t             level;
  logic             lvl_upd;
  lvl_t             gain_q;
  lvl_t             duty_sel;

  agc_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  agc_power #(.SAMPLE_W(SAMPLE_W)) u_power (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .smp_vld (smp_vld),
    .smp_i   (smp_i),
    .smp_q   (smp_q),
    .pwr_vld (pwr_vld),
    .pwr     (pwr)
  );

  agc_integrator #(.TIMER_BASE(TIMER_BASE)) u_integ (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .pwr_vld (pwr_vld),
    .pwr     (pwr),
    .code    (cfg_interval),
    .level   (level),
    .lvl_upd (lvl_upd)
  );

  agc_gain_loop u_gain (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .cfg_direct (cfg_direct),
    .cfg_byte   (cfg_byte),
    .level      (level),
    .lvl_upd    (lvl_upd),
    .gain       (gain_q)
  );

  assign duty_sel = cfg_direct ? cfg_byte : gain_q;

  agc_pwm u_pwm (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .duty    (duty_sel),
    .pol_pos (cfg_pol_pos),
    .pwm_o   (pwm_o)
  );

  assign lvl_rd = level;
endmodule

// File: rtl/agc_ctrl_chk.sv
module agc_ctrl_chk
  import agc_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic cfg_direct,
  input lvl_t cfg_byte,
  input logic lvl_upd,
  input lvl_t gain
);
  // R5: a window end in regulate mode moves the gain by at most one step
  p_gain_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_direct && lvl_upd && gain != 8'hFF && gain != 8'h00) |=>
      (gain == $past(gain) || (gain - $past(gain)) == 8'd1 || ($past(gain) - gain) == 8'd1));

  // R5: without a window end the regulated gain does not move
  p_gain_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_direct && !lvl_upd) |=> $stable(gain));

  // R6: no wrap at the top
  p_sat_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_direct && lvl_upd && gain == 8'hFF) |=> (gain == 8'hFF || gain == 8'hFE));

  // R6: no wrap at the bottom
  p_sat_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_direct && lvl_upd && gain == 8'h00) |=> (gain == 8'h00 || gain == 8'h01));

  // R7: in direct mode the gain follows the host byte one cycle later
  p_direct_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_direct |=> (gain == $past(cfg_byte)));
endmodule

bind agc_ctrl agc_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .cfg_direct (cfg_direct),
  .cfg_byte   (cfg_byte),
  .lvl_upd    (lvl_upd),
  .gain       (gain_q)
);

// File: tb/agc_ctrl_bench.sv
module agc_ctrl_bench;
  localparam int SW = 8;
  localparam int TB = 4;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              smp_vld;
  logic [SW-1:0]     smp_i, smp_q;
  logic [7:0]        cfg_byte;
  logic              cfg_direct;
  logic              cfg_pol_pos;
  logic [2:0]        cfg_interval;
  logic [7:0]        lvl_rd;
  logic              pwm_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int exp_lvl = 0;
  int exp_gain = 0;

  always #4 clk = ~clk;

  agc_ctrl #(.SAMPLE_W(SW), .TIMER_BASE(TB)) u_agc_ctrl (
    .clk (clk), .rst_n (rst_n), .smp_vld (smp_vld), .smp_i (smp_i), .smp_q (smp_q),
    .cfg_byte (cfg_byte), .cfg_direct (cfg_direct), .cfg_pol_pos (cfg_pol_pos),
    .cfg_interval (cfg_interval), .lvl_rd (lvl_rd), .pwm_o (pwm_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int next_gain(input int g, input int lvl, input int tgt);
    if (lvl < tgt && g < 255) return g + 1;
    if (lvl > tgt && g > 0) return g - 1;
    return g;
  endfunction

  // One full window; kind 0 = constant (a,b), kind 1 = random within +-a / +-b.
  task automatic run_window(input int code, input int kind, input int a, input int b,
                            input bit gaps, input bit master, input int tgt);
    int n;
    longint sum;
    n = 1 << (TB + code);
    sum = 0;
    @(negedge clk);
    cfg_interval = 3'(code);
    for (int k = 0; k < n; k++) begin
      int vi, vq;
      if (gaps && $urandom_range(0, 3) == 0) begin
        @(negedge clk);
        smp_vld = 1'b0;
        smp_i = 8'($urandom);
        smp_q = 8'($urandom);
      end
      if (kind == 0) begin
        vi = a; vq = b;
      end else begin
        vi = int'($urandom_range(0, 2 * a)) - a;
        vq = int'($urandom_range(0, 2 * b)) - b;
      end
      if (k == n - 1) begin
        @(negedge clk);
        smp_vld = 1'b0;
        repeat (4) @(negedge clk);
        check("R2 R3 level held before window end", int'(lvl_rd), exp_lvl);
      end
      @(negedge clk);
      smp_vld = 1'b1;
      smp_i = 8'(vi);
      smp_q = 8'(vq);
      sum += longint'(vi * vi + vq * vq);
    end
    @(negedge clk);
    smp_vld = 1'b0;
    exp_lvl = int'((sum >> (TB + code)) >> 8) & 255;
    if (master) exp_gain = next_gain(exp_gain, exp_lvl, tgt);
    repeat (5) @(negedge clk);
    check("R1 R2 level after window", int'(lvl_rd), exp_lvl);
  endtask

  task automatic measure_pwm(output int highs);
    repeat (600) @(negedge clk);
    highs = 0;
    repeat (256) begin
      @(negedge clk);
      if (pwm_o) highs++;
    end
  endtask

  task automatic set_direct(input int b);
    @(negedge clk);
    cfg_direct = 1'b1;
    cfg_byte = 8'(b);
    exp_gain = b;
  endtask

  task automatic to_master(input int tgt);
    @(negedge clk);
    cfg_direct = 1'b0;
    cfg_byte = 8'(tgt);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    int cyc;
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 190000 && !done) begin
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=<190000", cyc);
        finish_run();
      end
    end
  end

  initial begin
    int h;
    int duties[6];
    void'($urandom(32'd2024));
    rst_n = 1'b0; smp_vld = 1'b0; smp_i = '0; smp_q = '0;
    cfg_byte = 8'h00; cfg_direct = 1'b1; cfg_pol_pos = 1'b1; cfg_interval = 3'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R9 reset state
    check("R9 readback after reset", int'(lvl_rd), 0);
    check("R9 pin after reset", int'(pwm_o), 0);
    measure_pwm(h);
    check("R9 no pulses with zero gain", h, 0);

    // R4 and R8: direct duty, positive sense
    duties = '{0, 64, 255, 1, int'($urandom_range(2, 254)), int'($urandom_range(2, 254))};
    foreach (duties[d]) begin
      set_direct(duties[d]);
      measure_pwm(h);
      check("R4 R8 direct duty high time", h, duties[d]);
    end
    // R8: inverted sense
    @(negedge clk) cfg_pol_pos = 1'b0;
    set_direct(64);  measure_pwm(h); check("R8 inverted duty 0x40", h, 192);
    set_direct(0);   measure_pwm(h); check("R8 inverted duty 0x00", h, 256);
    set_direct(255); measure_pwm(h); check("R8 inverted duty 0xFF", h, 1);
    @(negedge clk) cfg_pol_pos = 1'b1;

    // R1 R2 R3: level estimation in direct mode
    set_direct(16);
    run_window(0, 0, 64, 64, 1'b0, 1'b0, 0);
    check("R1 constant 64,64 gives 0x20", int'(lvl_rd), 32);
    run_window(1, 0, -128, -128, 1'b1, 1'b0, 0);
    check("R1 full scale gives 0x80", int'(lvl_rd), 128);
    run_window(0, 0, 16, 0, 1'b0, 1'b0, 0);
    check("R1 small level gives 0x01", int'(lvl_rd), 1);
    run_window(2, 1, 100, 100, 1'b1, 1'b0, 0);
    run_window(3, 1, 127, 60, 1'b1, 1'b0, 0);

    // R7: regulation resumes from the last direct gain
    set_direct(48);
    to_master(32);
    measure_pwm(h);
    check("R7 gain kept across mode change", h, 48);

    // R5: hold on equal, rise when low, fall when high
    run_window(0, 0, 64, 64, 1'b0, 1'b1, 32);
    measure_pwm(h); check("R5 hold at target", h, exp_gain);
    repeat (3) run_window(0, 0, 16, 16, 1'b0, 1'b1, 32);
    measure_pwm(h); check("R5 rise below target", h, 51);
    repeat (2) run_window(0, 0, 127, 127, 1'b1, 1'b1, 32);
    measure_pwm(h); check("R5 fall above target", h, 49);

    // R6: saturation at both ends
    set_direct(254);
    to_master(255);
    repeat (3) run_window(0, 0, 16, 16, 1'b0, 1'b1, 255);
    measure_pwm(h); check("R6 saturate at 0xFF", h, 255);
    set_direct(1);
    to_master(0);
    repeat (3) run_window(0, 0, 16, 0, 1'b0, 1'b1, 0);
    measure_pwm(h); check("R6 saturate at 0x00", h, 0);

    // R5 random regulation
    set_direct(int'($urandom_range(0, 255)));
    for (int it = 0; it < 8; it++) begin
      int tgt, amp;
      tgt = int'($urandom_range(0, 128));
      amp = int'($urandom_range(1, 127));
      to_master(tgt);
      run_window(int'($urandom_range(0, 2)), 1, amp, amp, 1'b1, 1'b1, tgt);
      measure_pwm(h);
      check("R5 random regulation step", h, exp_gain);
    end

    finish_run();
  end
endmodule